// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Self-Clearing Pulse Outputs

This block is an eight-pin general-purpose I/O port. A byte-wide register bus reaches it. Each pin has an output-enable bit and an output data bit. The four upper pins can also run in pulse mode. In that mode a data bit works as a trigger: writing 1 drives the pin low for a fixed number of clocks. The bit stays set while the pulse runs and clears itself when the pulse ends.

A control register chooses level or pulse mode for each upper pin. It also chooses push-pull drive, or a drive that releases the pin (tri-state) instead of driving it high. The data register can be written at its configuration index and also at a short direct alias address. A read of the alias returns the pin status. Each pin is modelled as an output value plus an output-enable, so the pad and any pull-up stay outside the block. Pin inputs pass through a two-flop synchronizer before they reach the status register.

Top module: `gpio_pulse_port`

## Requirements
- R1: The output-enable register is at address F0h, one bit per pin (1 = output). It resets to 00h. A pin whose enable bit is 0 never has `pin_oe` asserted.
- R2: The data register is at address F1h and resets to 0Fh. A write to alias address 06h updates it exactly as a write to F1h does. A read of F1h returns its current value.
- R3: Pins 0 to 3 drive `pin_out` equal to their data bit and `pin_oe` equal to their enable bit. Both change on the clock edge that captures the write.
- R4: In level mode (control bit 4+j = 0 for pin 4+j), an upper pin drives its data bit on `pin_out`.
- R5: In level mode, an upper pin whose drive bit (control bit j for pin 4+j) is 0 and whose data bit is 1 has `pin_oe` deasserted. With the drive bit at 1 it is push-pull.
- R6: In pulse mode, writing 1 to an idle upper data bit makes `pin_out` low for exactly PULSE_W clocks, starting at the capturing edge. The data bit reads 1 during the pulse and 0 after it.
- R7: While a pulse runs, writing 1 or 0 to that data bit has no effect: the pulse length stays the same and the bit stays set.
- R8: A read of F2h or of alias 06h returns `pin_in` as it was two clock edges earlier (two-flop synchronizer). F2h cannot be written.
- R9: The control register is at F3h. Bits 7:4 are the mode bits for pins 7:4 (1 = pulse). Bits 3:0 are the drive bits for pins 7:4 (1 = push-pull). It resets to 0Fh.
- R10: An idle pin in pulse mode drives `pin_out` = 1. Its `pin_oe` is asserted only when the pin's drive bit is 1. During a pulse the pin is driven low whenever its enable bit is 1.
- R11: A read of any other address returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on the address) |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Value to drive on each pin |
| pin_oe | output | 8 | Drive enable for each pin |

## Verification
Register writes, pin values and enables take effect at the edge that captures the write. They are therefore compared at the following falling edge. Read data is combinational and is checked a nanosecond after the address changes. The status value trails `pin_in` by two rising edges. The reference model shifts its own two-stage queue at each rising edge, and the bench checks a pattern both one edge and two edges after it changes. Pulse widths are counted by sampling the pin at every falling edge over a window longer than the pulse. The count must equal PULSE_W, including when the trigger bit is written again partway through the pulse.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int DW  = 8;
    localparam int NHI = 4;
    localparam int NLO = DW - NHI;

    localparam logic [7:0] IDX_OE  = 8'hF0;
    localparam logic [7:0] IDX_DAT = 8'hF1;
    localparam logic [7:0] IDX_STS = 8'hF2;
    localparam logic [7:0] IDX_CTL = 8'hF3;
    localparam logic [7:0] ADR_ALIAS = 8'h06;

    typedef struct packed {
        logic [DW-1:0]  oe;
        logic [NHI-1:0] mode;
        logic [NHI-1:0] drive;
        logic [NLO-1:0] dat_lo;
    } cfg_t;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_oe,
    input  logic          wr_ctl,
    input  logic          wr_dat,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg
);
    cfg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (wr_oe) begin
            c_d.oe = wdata;
        end
        if (wr_ctl) begin
            c_d.mode  = wdata[DW-1 -: NHI];
            c_d.drive = wdata[NHI-1:0];
        end
        if (wr_dat) begin
            c_d.dat_lo = wdata[NLO-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.oe     <= '0;
            c_q.mode   <= '0;
            c_q.drive  <= '1;
            c_q.dat_lo <= '1;
        end else begin
            c_q <= c_d;
        end
    end

    assign cfg = c_q;
endmodule

// File: rtl/gpio_pulse_lane.sv
module gpio_pulse_lane #(
    parameter int PULSE_W = 16,
    localparam int CW = (PULSE_W > 1) ? $clog2(PULSE_W) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          wbit,
    input  logic          mode,
    input  logic          drive,
    input  logic          oe_en,
    output logic          bit_o,
    output logic          pin_o,
    output logic          pin_oe_o,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_W - 1);

    typedef struct packed {
        logic          bit_v;
        logic [CW-1:0] cnt;
    } lane_t;

    lane_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (!mode) begin
            l_d.cnt = '0;
            if (wr) begin
                l_d.bit_v = wbit;
            end
        end else if (l_q.bit_v) begin
            if (l_q.cnt == '0) begin
                l_d.bit_v = 1'b0;
            end else begin
                l_d.cnt = l_q.cnt - 1'b1;
            end
        end else if (wr && wbit) begin
            l_d.bit_v = 1'b1;
            l_d.cnt   = LOAD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    always_comb begin
        if (mode) begin
            pin_o    = ~l_q.bit_v;
            pin_oe_o = oe_en & (l_q.bit_v | drive);
        end else begin
            pin_o    = l_q.bit_v;
            pin_oe_o = oe_en & ~(l_q.bit_v & ~drive);
        end
    end

    assign bit_o = l_q.bit_v;
    assign cnt_o = l_q.cnt;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.s1 = din;
        s_d.s2 = s_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout = s_q.s2;
endmodule

// File: rtl/gpio_pulse_port.sv
module gpio_pulse_port
    import gpio_pkg::*;
#(
    parameter int PULSE_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_we,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic [7:0] pin_in,
    output logic [7:0] pin_out,
    output logic [7:0] pin_oe
);
    localparam int CW = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;

    cfg_t                   cfg;
    logic                   wr_oe, wr_ctl, wr_dat;
    logic [DW-1:0]          oe_q, dat_q, sts_q;
    logic [NHI-1:0]         mode_q, drive_q, hi_bits;
    logic [NHI-1:0][CW-1:0] cnt_q;

    assign wr_oe  = bus_we && (bus_addr == IDX_OE);
    assign wr_ctl = bus_we && (bus_addr == IDX_CTL);
    assign wr_dat = bus_we && ((bus_addr == IDX_DAT) || (bus_addr == ADR_ALIAS));

    gpio_cfg_regs u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_oe  (wr_oe),
        .wr_ctl (wr_ctl),
        .wr_dat (wr_dat),
        .wdata  (bus_wdata),
        .cfg    (cfg)
    );

    assign oe_q    = cfg.oe;
    assign mode_q  = cfg.mode;
    assign drive_q = cfg.drive;

    assign pin_out[NLO-1:0] = cfg.dat_lo;
    assign pin_oe[NLO-1:0]  = cfg.oe[NLO-1:0];

    for (genvar j = 0; j < NHI; j++) begin : g_lane
        gpio_pulse_lane #(.PULSE_W(PULSE_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (wr_dat),
            .wbit     (bus_wdata[NLO+j]),
            .mode     (cfg.mode[j]),
            .drive    (cfg.drive[j]),
            .oe_en    (cfg.oe[NLO+j]),
            .bit_o    (hi_bits[j]),
            .pin_o    (pin_out[NLO+j]),
            .pin_oe_o (pin_oe[NLO+j]),
            .cnt_o    (cnt_q[j])
        );
    end

    assign dat_q = {hi_bits, cfg.dat_lo};

    gpio_in_sync #(.W(DW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (sts_q)
    );

    always_comb begin
        case (bus_addr)
            IDX_OE:             bus_rdata = oe_q;
            IDX_DAT:            bus_rdata = dat_q;
            IDX_STS, ADR_ALIAS: bus_rdata = sts_q;
            IDX_CTL:            bus_rdata = {mode_q, drive_q};
            default:            bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pulse_port_chk.sv
module gpio_pulse_port_chk
    import gpio_pkg::*;
#(
    parameter int PULSE_W = 16,
    localparam int CW = (PULSE_W > 1) ? $clog2(PULSE_W) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_we,
    input logic [7:0]             bus_addr,
    input logic [7:0]             bus_wdata,
    input logic [7:0]             bus_rdata,
    input logic [7:0]             pin_in,
    input logic [7:0]             pin_out,
    input logic [7:0]             pin_oe,
    input logic [DW-1:0]          oe_q,
    input logic [DW-1:0]          dat_q,
    input logic [NHI-1:0]         mode_q,
    input logic [NHI-1:0]         drive_q,
    input logic [NHI-1:0][CW-1:0] cnt_q
);
    logic [1:0] age_q;
    logic       dat_hit;

    assign dat_hit = bus_we && ((bus_addr == IDX_DAT) || (bus_addr == ADR_ALIAS));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    // R1
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~oe_q) == 8'h00);

    // R2
    alias_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADR_ALIAS) |=> dat_q[NLO-1:0] == $past(bus_wdata[NLO-1:0]));

    // R8
    sts_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && bus_addr == IDX_STS) |-> bus_rdata == $past(pin_in, 2));

    for (genvar j = 0; j < NHI; j++) begin : g_chk
        // R5
        tri_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_q[j] && dat_q[NLO+j] && !drive_q[j]) |-> !pin_oe[NLO+j]);

        // R6
        pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[j] && !dat_q[NLO+j] && dat_hit && bus_wdata[NLO+j])
            |=> (dat_q[NLO+j] && !pin_out[NLO+j]));

        // R7
        pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[j] && dat_q[NLO+j] && cnt_q[j] != '0 && !(bus_we && bus_addr == IDX_CTL))
            |=> (dat_q[NLO+j] && cnt_q[j] == $past(cnt_q[j]) - 1'b1));
    end
endmodule

bind gpio_pulse_port gpio_pulse_port_chk #(.PULSE_W(PULSE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .oe_q      (oe_q),
    .dat_q     (dat_q),
    .mode_q    (mode_q),
    .drive_q   (drive_q),
    .cnt_q     (cnt_q)
);

// File: tb/sim_gpio_pulse_port.sv
module sim_gpio_pulse_port;
    localparam int PW = 16;

    logic       clk = 1'b0;
    logic       rst_n, bus_we;
    logic [7:0] bus_addr, bus_wdata, pin_in;
    logic [7:0] bus_rdata, pin_out, pin_oe;

    always #5 clk = ~clk;

    gpio_pulse_port #(.PULSE_W(PW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit cmp_en  = 1'b0;
    bit done    = 1'b0;
    bit meas    = 1'b0;
    int lowcnt  = 0;

    // behavioural reference state
    logic [7:0] m_oe, m_dat, m_s1, m_s2;
    logic [3:0] m_mode, m_drv;
    int         m_cnt [4];

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_oe = 8'h00; m_dat = 8'h0F; m_mode = 4'h0; m_drv = 4'hF;
            m_s1 = 8'h00; m_s2 = 8'h00;
            for (int j = 0; j < 4; j++) m_cnt[j] = 0;
        end else begin
            automatic bit wd = bus_we && (bus_addr == 8'hF1 || bus_addr == 8'h06);
            m_s2 = m_s1;
            m_s1 = pin_in;
            for (int j = 0; j < 4; j++) begin
                if (!m_mode[j]) begin
                    m_cnt[j] = 0;
                    if (wd) m_dat[4+j] = bus_wdata[4+j];
                end else if (m_dat[4+j]) begin
                    if (m_cnt[j] == 0) m_dat[4+j] = 1'b0;
                    else m_cnt[j] = m_cnt[j] - 1;
                end else if (wd && bus_wdata[4+j]) begin
                    m_dat[4+j] = 1'b1;
                    m_cnt[j] = PW - 1;
                end
            end
            if (wd) m_dat[3:0] = bus_wdata[3:0];
            if (bus_we && bus_addr == 8'hF0) m_oe = bus_wdata;
            if (bus_we && bus_addr == 8'hF3) begin
                m_mode = bus_wdata[7:4];
                m_drv  = bus_wdata[3:0];
            end
        end
    end

    function automatic logic [7:0] e_out();
        logic [7:0] v;
        for (int i = 0; i < 8; i++) begin
            if (i >= 4 && m_mode[i-4]) v[i] = ~m_dat[i];
            else v[i] = m_dat[i];
        end
        return v;
    endfunction

    function automatic logic [7:0] e_oe();
        logic [7:0] v;
        for (int i = 0; i < 8; i++) begin
            if (i < 4) v[i] = m_oe[i];
            else if (m_mode[i-4]) v[i] = m_oe[i] & (m_dat[i] | m_drv[i-4]);
            else v[i] = m_oe[i] & ~(m_dat[i] & ~m_drv[i-4]);
        end
        return v;
    endfunction

    always @(negedge clk) begin
        if (cmp_en) begin
            chk(pin_out === e_out(), "R3 R4 R6 pin_out", pin_out, e_out());
            chk(pin_oe === e_oe(), "R1 R5 R10 pin_oe", pin_oe, e_oe());
            case (bus_addr)
                8'hF0: chk(bus_rdata === m_oe, "R1 read", bus_rdata, m_oe);
                8'hF1: chk(bus_rdata === m_dat, "R2 read", bus_rdata, m_dat);
                8'hF2, 8'h06: chk(bus_rdata === m_s2, "R8 read", bus_rdata, m_s2);
                8'hF3: chk(bus_rdata === {m_mode, m_drv}, "R9 read", bus_rdata, {m_mode, m_drv});
                default: chk(bus_rdata === 8'h00, "R11 read", bus_rdata, 8'h00);
            endcase
            if (meas && !pin_out[4]) lowcnt++;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
        bus_addr = a;
        #1;
        chk(bus_rdata === exp, req, bus_rdata, exp);
    endtask

    initial begin
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00; pin_in = 8'h00;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // reset values
        rd(8'hF0, 8'h00, "R1 reset oe");
        rd(8'hF1, 8'h0F, "R2 reset data");
        rd(8'hF3, 8'h0F, "R9 reset ctrl");
        chk(pin_oe === 8'h00, "R1 reset pin_oe", pin_oe, 8'h00);

        wr(8'hF0, 8'hFF);
        chk(pin_out[3:0] === 4'hF, "R3 low pins", {4'h0, pin_out[3:0]}, 8'h0F);
        wr(8'hF1, 8'hA5);
        chk(pin_out === 8'hA5, "R4 level out", pin_out, 8'hA5);
        chk(pin_oe === 8'hFF, "R5 push-pull", pin_oe, 8'hFF);
        wr(8'hF3, 8'h00);
        chk(pin_oe === 8'h5F, "R5 tri-state high", pin_oe, 8'h5F);
        wr(8'h06, 8'h5A);
        rd(8'hF1, 8'h5A, "R2 alias write");
        chk(pin_oe === 8'hAF, "R5 alias level", pin_oe, 8'hAF);
        wr(8'hF0, 8'h3C);
        chk(pin_out[3:0] === 4'hA, "R3 data hold", {4'h0, pin_out[3:0]}, 8'h0A);

        // input synchronizer
        bus_addr = 8'hF2;
        pin_in = 8'hC3;
        idle(2);
        rd(8'hF2, 8'hC3, "R8 two edges");
        pin_in = 8'h3C;
        idle(1);
        rd(8'hF2, 8'hC3, "R8 one edge old");
        idle(1);
        rd(8'h06, 8'h3C, "R8 alias read");
        for (int k = 0; k < 6; k++) begin
            pin_in = 8'(k * 37 + 11);
            idle(1);
        end
        wr(8'hF2, 8'hFF);
        rd(8'hF2, m_s2, "R8 not writable");

        // pulse mode, push-pull
        wr(8'hF0, 8'hFF);
        wr(8'hF1, 8'h00);
        wr(8'hF3, 8'hFF);
        chk(pin_out[7:4] === 4'hF, "R10 idle high", {pin_out[7:4], 4'h0}, 8'hF0);
        lowcnt = 0; meas = 1'b1;
        wr(8'hF1, 8'h10);
        rd(8'hF1, 8'h10, "R6 bit set during pulse");
        idle(PW + 8);
        meas = 1'b0;
        chk(lowcnt == PW, "R6 pulse width", 8'(lowcnt), 8'(PW));
        rd(8'hF1, 8'h00, "R6 self clear");

        // retrigger and clear during a pulse
        lowcnt = 0; meas = 1'b1;
        wr(8'hF1, 8'h10);
        idle(3);
        wr(8'hF1, 8'h10);
        wr(8'hF1, 8'h00);
        rd(8'hF1, 8'h10, "R7 bit still set");
        idle(PW + 8);
        meas = 1'b0;
        chk(lowcnt == PW, "R7 pulse width unchanged", 8'(lowcnt), 8'(PW));

        // pulse mode with tri-state idle
        wr(8'hF3, 8'hF0);
        chk(pin_oe === 8'h0F, "R10 idle released", pin_oe, 8'h0F);
        wr(8'hF1, 8'h80);
        chk(pin_oe[7] === 1'b1 && pin_out[7] === 1'b0, "R10 driven low in pulse",
            {pin_oe[7], pin_out[7], 6'h0}, 8'h80);
        idle(PW + 4);
        wr(8'hF3, 8'hFF);
        wr(8'hF1, 8'hF3);
        idle(PW + 4);

        rd(8'h33, 8'h00, "R11 unmapped");
        idle(2);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule